// File: doc/BRIEF.md
# Interleaved Cache-Line Fill Sequencer

The block carries a 64-byte cache line across the boundary between a 64-bit external data bus and a 128-bit internal bus. On the inbound (fill) side it accepts eight 8-byte beats, each one qualified by its own valid strobe. It joins every pair of beats into one 16-byte octaword. It then presents that octaword on the internal bus, tagged with its position in the line. On the outbound (victim or probe-read) side it reads the line's four octawords from a line buffer and sends them out as eight consecutive beats.

The external side never moves beats in linear order. The system names a starting octaword with a 2-bit field. Beat `i` then holds quadword `{start,0} XOR i`. Each even/odd pair of beats is therefore one aligned octaword, with its lower quadword first. Both directions use this order and run independently of each other. A start command that arrives while its own direction is busy is dropped.

Top module: `line_fill_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it is released, `fill_ow_vld`, `fill_done` and `vict_beat_vld` are low. Both directions are idle.
- R2: An inbound beat is taken only in a cycle where `fill_beat_vld` is high and a fill has already been started by an earlier `fill_start`. Strobes that arrive while idle, and cycles without the strobe, advance nothing.
- R3: Accepted beat `i` (0 to 7) of a fill holds quadword `{fill_start_ow,1'b0} XOR i`. An octaword's first beat lands in `fill_ow_data[63:0]` and its second beat lands in `fill_ow_data[127:64]`.
- R4: `fill_ow_vld` pulses for one cycle, in the cycle after the second beat of a pair is accepted. `fill_ow_idx` equals `fill_start_ow XOR k` for the k-th octaword (k = 0 to 3).
- R5: `fill_done` is high together with the fourth `fill_ow_vld` of a fill. After that the fill side is idle and accepts a new `fill_start`.
- R6: A `fill_start` raised during a fill, or a `vict_start` raised during a drain, is ignored. The running transfer's order and data do not change.
- R7: After `vict_start`, `vict_beat_vld` is high for exactly eight consecutive cycles, beginning one cycle after the start (with zero read latency). Beat `i` is the lower (i even) or upper (i odd) half of the buffer octaword `vict_start_ow XOR (i>>1)`. That octaword is addressed through `lb_rd_idx` while `lb_rd_en` is high.
- R8: A fill and a drain can run in the same cycles, including starting on the same edge, without affecting each other.
- R9: A reset in the middle of a fill drops the beats already collected. The next fill starts from beat 0 with fresh data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fill_start | input | 1 | Begin an inbound fill |
| fill_start_ow | input | 2 | First octaword of the fill |
| fill_beat_vld | input | 1 | Inbound beat qualifier |
| fill_beat_data | input | 64 | Inbound beat |
| fill_ow_vld | output | 1 | Assembled octaword valid pulse |
| fill_ow_data | output | 128 | Assembled octaword |
| fill_ow_idx | output | 2 | Octaword index within the line (address bits 5:4) |
| fill_done | output | 1 | Last octaword of the fill |
| vict_start | input | 1 | Begin an outbound transfer |
| vict_start_ow | input | 2 | First octaword of the outbound transfer |
| lb_rd_en | output | 1 | Line buffer read enable |
| lb_rd_idx | output | 2 | Line buffer octaword address |
| lb_rd_data | input | 128 | Line buffer read data |
| vict_beat_vld | output | 1 | Outbound beat valid |
| vict_beat_data | output | 64 | Outbound beat |

## Verification
The two directions can be active in the same cycle. An outbound beat can go out on the same edge that an inbound pair completes an octaword, and a start command for one side can coincide with the other side's last beat. The bench provokes this by starting a fill and a drain on the same edge, with different start octawords, and by sweeping the start values so that the two streams overlap. It also issues a second start on each side in the middle of its transfer. A behavioural model keeps a separate beat counter for each direction and checks every output of both sides on every cycle. A cross-coupling fault then shows up as a mismatch in the very cycle it occurs.

// File: rtl/lf_pkg.sv
package lf_pkg;
   typedef enum logic {
      LF_IDLE = 1'b0,
      LF_RUN  = 1'b1
   } lf_state_e;
endpackage

// File: rtl/lf_wrap_order.sv
module lf_wrap_order #(
   parameter int CNT_W = 3,
   localparam int IDX_W = CNT_W - 1
) (
   input  logic [IDX_W-1:0] start_blk,
   input  logic [CNT_W-1:0] beat_cnt,
   output logic [IDX_W-1:0] blk_idx,
   output logic             upper_half
);
   // interleaved wrap: quadword = {start,0} ^ cnt, so block = start ^ cnt[msb:1]
   assign blk_idx    = start_blk ^ beat_cnt[CNT_W-1:1];
   assign upper_half = beat_cnt[0];
endmodule

// File: rtl/lf_fill_pack.sv
module lf_fill_pack
   import lf_pkg::*;
#(
   parameter int QW_W  = 64,
   parameter int BEATS = 8,
   localparam int OW_W  = 2 * QW_W,
   localparam int CNT_W = $clog2(BEATS),
   localparam int IDX_W = CNT_W - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [IDX_W-1:0] start_idx,
   input  logic             beat_vld,
   input  logic [QW_W-1:0]  beat_data,
   output logic             ow_vld,
   output logic [OW_W-1:0]  ow_data,
   output logic [IDX_W-1:0] ow_idx,
   output logic             line_done
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

   lf_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] start_q;
   logic [QW_W-1:0]  low_q;
   logic [IDX_W-1:0] blk_idx;
   logic             upper;
   logic             accept;

   lf_wrap_order #(.CNT_W(CNT_W)) u_wrap (
      .start_blk  (start_q),
      .beat_cnt   (cnt_q),
      .blk_idx    (blk_idx),
      .upper_half (upper)
   );

   assign accept = (state_q == LF_RUN) && beat_vld;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= LF_IDLE;
         cnt_q     <= '0;
         start_q   <= '0;
         low_q     <= '0;
         ow_vld    <= 1'b0;
         ow_data   <= '0;
         ow_idx    <= '0;
         line_done <= 1'b0;
      end else begin
         ow_vld    <= 1'b0;
         line_done <= 1'b0;
         if (state_q == LF_IDLE) begin
            if (start) begin
               state_q <= LF_RUN;
               cnt_q   <= '0;
               start_q <= start_idx;
            end
         end else if (accept) begin
            cnt_q <= cnt_q + 1'b1;
            if (!upper) begin
               low_q <= beat_data;
            end else begin
               ow_vld  <= 1'b1;
               ow_data <= {beat_data, low_q};
               ow_idx  <= blk_idx;
               if (cnt_q == LAST) begin
                  line_done <= 1'b1;
                  state_q   <= LF_IDLE;
               end
            end
         end
      end
   end

   // pairs take two accepted beats, so words never come back to back
   p_ow_spacing_r4: assert property (@(posedge clk) disable iff (rst)
      ow_vld |=> !ow_vld);
   p_done_with_word_r5: assert property (@(posedge clk) disable iff (rst)
      line_done |-> ow_vld);
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      (state_q == LF_IDLE) |=> !ow_vld);
   p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
      accept |=> (cnt_q == $past(cnt_q) + 1'b1));
   p_restart_ignored_r6: assert property (@(posedge clk) disable iff (rst)
      (state_q == LF_RUN && start && !beat_vld) |=>
         (state_q == LF_RUN && $stable(cnt_q) && $stable(start_q)));
endmodule

// File: rtl/lf_drain_ser.sv
module lf_drain_ser
   import lf_pkg::*;
#(
   parameter int QW_W   = 64,
   parameter int BEATS  = 8,
   parameter int RD_LAT = 0,
   localparam int OW_W  = 2 * QW_W,
   localparam int CNT_W = $clog2(BEATS),
   localparam int IDX_W = CNT_W - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [IDX_W-1:0] start_idx,
   output logic             rd_en,
   output logic [IDX_W-1:0] rd_idx,
   input  logic [OW_W-1:0]  rd_data,
   output logic             beat_vld,
   output logic [QW_W-1:0]  beat_data
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

   lf_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] start_q;
   logic             upper;
   logic             sel_vld;
   logic             sel_hi;

   lf_wrap_order #(.CNT_W(CNT_W)) u_wrap (
      .start_blk  (start_q),
      .beat_cnt   (cnt_q),
      .blk_idx    (rd_idx),
      .upper_half (upper)
   );

   assign rd_en = (state_q == LF_RUN);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= LF_IDLE;
         cnt_q   <= '0;
         start_q <= '0;
      end else if (state_q == LF_IDLE) begin
         if (start) begin
            state_q <= LF_RUN;
            cnt_q   <= '0;
            start_q <= start_idx;
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LAST) state_q <= LF_IDLE;
      end
   end

   // align the half select with the buffer's read latency
   generate
      if (RD_LAT == 0) begin : g_lat0
         assign sel_vld = rd_en;
         assign sel_hi  = upper;
         p_beat_follows_r7: assert property (@(posedge clk) disable iff (rst)
            rd_en |=> beat_vld);
      end else begin : g_lat1
         logic vld_q, hi_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               vld_q <= 1'b0;
               hi_q  <= 1'b0;
            end else begin
               vld_q <= rd_en;
               hi_q  <= upper;
            end
         end
         assign sel_vld = vld_q;
         assign sel_hi  = hi_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         beat_vld  <= 1'b0;
         beat_data <= '0;
      end else begin
         beat_vld <= sel_vld;
         if (sel_vld) beat_data <= sel_hi ? rd_data[OW_W-1:QW_W] : rd_data[QW_W-1:0];
      end
   end

   p_burst_unbroken_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_en && cnt_q != LAST) |=> rd_en);
   p_burst_ends_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_en && cnt_q == LAST) |=> !rd_en);
   p_restart_ignored_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_en && start) |=> $stable(start_q));
endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq #(
   parameter int QW_W   = 64,
   parameter int BEATS  = 8,
   parameter int RD_LAT = 0,
   localparam int OW_W  = 2 * QW_W,
   localparam int CNT_W = $clog2(BEATS),
   localparam int IDX_W = CNT_W - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fill_start,
   input  logic [IDX_W-1:0] fill_start_ow,
   input  logic             fill_beat_vld,
   input  logic [QW_W-1:0]  fill_beat_data,
   output logic             fill_ow_vld,
   output logic [OW_W-1:0]  fill_ow_data,
   output logic [IDX_W-1:0] fill_ow_idx,
   output logic             fill_done,
   input  logic             vict_start,
   input  logic [IDX_W-1:0] vict_start_ow,
   output logic             lb_rd_en,
   output logic [IDX_W-1:0] lb_rd_idx,
   input  logic [OW_W-1:0]  lb_rd_data,
   output logic             vict_beat_vld,
   output logic [QW_W-1:0]  vict_beat_data
);
   generate
      if (BEATS < 4 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
         $error("line_fill_seq: BEATS must be a power of two, at least 4");
      end
      if (RD_LAT != 0 && RD_LAT != 1) begin : g_bad_lat
         $error("line_fill_seq: RD_LAT must be 0 or 1");
      end
   endgenerate

   lf_fill_pack #(.QW_W(QW_W), .BEATS(BEATS)) u_fill (
      .clk       (clk),
      .rst       (rst),
      .start     (fill_start),
      .start_idx (fill_start_ow),
      .beat_vld  (fill_beat_vld),
      .beat_data (fill_beat_data),
      .ow_vld    (fill_ow_vld),
      .ow_data   (fill_ow_data),
      .ow_idx    (fill_ow_idx),
      .line_done (fill_done)
   );

   lf_drain_ser #(.QW_W(QW_W), .BEATS(BEATS), .RD_LAT(RD_LAT)) u_drain (
      .clk       (clk),
      .rst       (rst),
      .start     (vict_start),
      .start_idx (vict_start_ow),
      .rd_en     (lb_rd_en),
      .rd_idx    (lb_rd_idx),
      .rd_data   (lb_rd_data),
      .beat_vld  (vict_beat_vld),
      .beat_data (vict_beat_data)
   );
endmodule

// File: tb/line_fill_seq_bench.sv
module line_fill_seq_bench;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         fs = 1'b0;
   logic [1:0]   fs_ow = '0;
   logic         bv = 1'b0;
   logic [63:0]  bd = '0;
   logic         ow_vld, done, lb_en, vb_vld;
   logic [127:0] ow_data;
   logic [1:0]   ow_idx, lb_idx;
   logic         vs = 1'b0;
   logic [1:0]   vs_ow = '0;
   logic [63:0]  vb_data;
   logic [127:0] lbm [4];
   logic [127:0] lb_data;

   int checks = 0;
   int errs   = 0;
   string phase = "R1 reset";

   always #2.5 clk = ~clk;

   assign lb_data = lbm[lb_idx];

   line_fill_seq u_line_fill_seq (
      .clk(clk), .rst(rst),
      .fill_start(fs), .fill_start_ow(fs_ow),
      .fill_beat_vld(bv), .fill_beat_data(bd),
      .fill_ow_vld(ow_vld), .fill_ow_data(ow_data), .fill_ow_idx(ow_idx), .fill_done(done),
      .vict_start(vs), .vict_start_ow(vs_ow),
      .lb_rd_en(lb_en), .lb_rd_idx(lb_idx), .lb_rd_data(lb_data),
      .vict_beat_vld(vb_vld), .vict_beat_data(vb_data)
   );

   // behavioural reference model
   int m_fact = 0, m_fcnt = 0, m_fst = 0;
   int m_dact = 0, m_dcnt = 0, m_dst = 0;
   logic [63:0]  m_low = '0;
   logic         e_ow_vld = 0, e_done = 0, e_vb_vld = 0, started = 0;
   logic [127:0] e_ow_data = '0;
   logic [1:0]   e_ow_idx = '0;
   logic [63:0]  e_vb_data = '0;

   always @(posedge clk) begin
      started  <= 1'b1;
      e_ow_vld <= 1'b0;
      e_done   <= 1'b0;
      e_vb_vld <= 1'b0;
      if (rst) begin
         m_fact = 0; m_fcnt = 0; m_dact = 0; m_dcnt = 0;
      end else begin
         if (m_fact != 0) begin
            if (bv) begin
               if (m_fcnt % 2 == 0) m_low = bd;
               else begin
                  e_ow_vld  <= 1'b1;
                  e_ow_data <= {bd, m_low};
                  e_ow_idx  <= 2'(m_fst ^ (m_fcnt / 2));
                  if (m_fcnt == 7) e_done <= 1'b1;
               end
               m_fcnt++;
               if (m_fcnt == 8) m_fact = 0;
            end
         end else if (fs) begin
            m_fact = 1; m_fcnt = 0; m_fst = int'(fs_ow);
         end
         if (m_dact != 0) begin
            e_vb_vld  <= 1'b1;
            e_vb_data <= (m_dcnt % 2 == 1) ? lbm[m_dst ^ (m_dcnt / 2)][127:64]
                                           : lbm[m_dst ^ (m_dcnt / 2)][63:0];
            m_dcnt++;
            if (m_dcnt == 8) m_dact = 0;
         end else if (vs) begin
            m_dact = 1; m_dcnt = 0; m_dst = int'(vs_ow);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s (%s) %s act %h exp %h", req, phase, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         chk(ow_vld == e_ow_vld, "R4", "fill_ow_vld", 128'(ow_vld), 128'(e_ow_vld));
         chk(done == e_done, "R5", "fill_done", 128'(done), 128'(e_done));
         chk(vb_vld == e_vb_vld, "R7", "vict_beat_vld", 128'(vb_vld), 128'(e_vb_vld));
         if (e_ow_vld) begin
            chk(ow_idx == e_ow_idx, "R4", "fill_ow_idx", 128'(ow_idx), 128'(e_ow_idx));
            chk(ow_data == e_ow_data, "R3", "fill_ow_data", ow_data, e_ow_data);
         end
         if (e_vb_vld)
            chk(vb_data == e_vb_data, "R7", "vict_beat_data", 128'(vb_data), 128'(e_vb_data));
      end
   end

   task automatic fill_go(input logic [1:0] ow);
      @(negedge clk); fs = 1'b1; fs_ow = ow;
      @(negedge clk); fs = 1'b0;
   endtask

   task automatic vict_go(input logic [1:0] ow);
      @(negedge clk); vs = 1'b1; vs_ow = ow;
      @(negedge clk); vs = 1'b0;
   endtask

   task automatic send_beats(input int n, input int gap, input logic [31:0] tagv);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); bv = 1'b1; bd = {tagv, 32'(i)};
         if (gap > 0) begin
            @(negedge clk); bv = 1'b0;
            repeat (gap - 1) @(negedge clk);
         end
      end
      @(negedge clk); bv = 1'b0;
   endtask

   task automatic load_buf(input logic [31:0] seed);
      for (int k = 0; k < 4; k++)
         lbm[k] = {seed, 32'(k) + 32'h100, seed ^ 32'hA5A5_0000, 32'(k)};
   endtask

   initial begin
      load_buf(32'h1111_0000);
      repeat (3) @(negedge clk);
      chk(!ow_vld && !done && !vb_vld, "R1", "outputs in reset", 128'({ow_vld, done, vb_vld}), 128'(0));
      rst = 1'b0;
      @(negedge clk);
      chk(!ow_vld && !done && !vb_vld, "R1", "outputs after reset", 128'({ow_vld, done, vb_vld}), 128'(0));

      phase = "R2 idle strobes ignored";
      send_beats(3, 0, 32'hDEAD_0000);
      chk(!ow_vld, "R2", "no word while idle", 128'(ow_vld), 128'(0));

      phase = "R3 R4 R5 fill start 0 back to back";
      fill_go(2'd0);
      send_beats(8, 0, 32'hA000_0000);
      repeat (2) @(negedge clk);

      phase = "R2 fill start 2 with gaps";
      fill_go(2'd2);
      send_beats(8, 2, 32'hB000_0000);
      repeat (2) @(negedge clk);

      phase = "R6 restart during fill";
      fill_go(2'd3);
      send_beats(3, 1, 32'hC000_0000);
      fill_go(2'd1);
      send_beats(5, 0, 32'hC100_0000);
      repeat (2) @(negedge clk);

      phase = "R7 drain start 1";
      vict_go(2'd1);
      repeat (10) @(negedge clk);

      phase = "R6 restart during drain";
      load_buf(32'h2222_0000);
      vict_go(2'd2);
      vict_go(2'd0);
      repeat (10) @(negedge clk);

      phase = "R8 concurrent fill and drain";
      for (int s = 0; s < 4; s++) begin
         load_buf(32'h3300_0000 + 32'(s));
         fork
            begin fill_go(2'(s)); send_beats(8, s % 2, 32'hD000_0000 + 32'(s)); end
            vict_go(2'(3 - s));
         join
         repeat (10) @(negedge clk);
      end

      phase = "R9 reset mid fill";
      fill_go(2'd1);
      send_beats(3, 0, 32'hE000_0000);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk(!ow_vld && !done, "R9", "quiet after reset", 128'({ow_vld, done}), 128'(0));
      phase = "R9 fresh fill after reset";
      fill_go(2'd2);
      send_beats(8, 0, 32'hF000_0000);
      repeat (4) @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end
endmodule